// File: doc/BRIEF.md
# Serial Two's Complement Converter

This block negates an unsigned binary number that arrives one bit per clock, least significant bit first. Whenever the valid strobe is high it takes in one data bit and, in that same cycle, drives one result bit. At every point in the stream, the result bits produced so far are the two's complement of the data bits taken in so far, counting the current bit. The complement is taken modulo two to the power of the number of bits seen.

The rule needs one stored bit. It records whether a 1 has arrived yet. Until the first 1, each result bit copies its data bit, and the first 1 itself passes through unchanged. Every later data bit comes out inverted. The result is combinational on the current data bit, so it carries no delay through a register.

A new number starts only after a synchronous reset. There is no framing signal.

Top module: `serial_negator`

## Requirements
- R1: After reset, while valid is high, each data bit up to and including the first 1 appears unchanged on the result in the same cycle.
- R2: A valid data bit of 1 taken in before any other 1 makes every later valid result bit the inverse of its data bit.
- R3: After k valid bits, the k result bits, read with the first one as bit 0, equal (2^k minus the input value) modulo 2^k.
- R4: While valid is low, the result is 0 and no stored state changes, so the next valid bit is treated exactly as if the idle cycle never happened.
- R5: Reset is synchronous and active high, and it overrides valid: a cycle with reset, valid and a data bit of 1 all high leaves the block in its start state.
- R6: Once inverting has begun, it continues through any number of valid and idle cycles until reset.
- R7: The result bit for a data bit is valid in the same cycle as that data bit, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high, overrides valid |
| vld_i | input | 1 | High when din_i carries a bit of the number |
| din_i | input | 1 | Serial data bit, least significant first |
| dout_o | output | 1 | Serial result bit, 0 when vld_i is low |

## Verification
The stored bit shows up on the very next valid cycle. Each result bit is the data bit exclusive-ORed with that stored bit, so a wrong state flips the result on the first valid bit after the fault, whatever value that bit has. If the state is lost during idle cycles or kept across a reset, the first valid bit afterwards comes out wrong. The bench rebuilds the whole word after every valid bit and compares it with the arithmetic negation, so a single wrong bit is reported in the cycle it appears.

// File: rtl/sn_pkg.sv
package sn_pkg;

    // Whether a 1 has been taken in since reset.
    typedef enum logic {
        ST_PASS   = 1'b0,
        ST_INVERT = 1'b1
    } neg_state_e;

    typedef struct packed {
        neg_state_e mode;
    } sn_regs_t;

endpackage

// File: rtl/sn_state.sv
module sn_state
    import sn_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       vld_i,
    input  logic       din_i,
    output neg_state_e mode_o
);

    sn_regs_t regs_d;
    sn_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst_i) begin
            regs_d.mode = ST_PASS;
        end else if (vld_i && din_i && regs_q.mode == ST_PASS) begin
            regs_d.mode = ST_INVERT;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign mode_o = regs_q.mode;

    // R5: reset overrides everything else
    a_r5_reset_to_pass: assert property (@(posedge clk_i)
        rst_i |=> (mode_o == ST_PASS));

    // R2: the first valid 1 arms inversion
    a_r2_first_one_arms: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && din_i && mode_o == ST_PASS) |=> (mode_o == ST_INVERT));

    // R4: idle cycles leave the state untouched
    a_r4_idle_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> $stable(mode_o));

    // R6: inversion is sticky until reset
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == ST_INVERT) |=> (mode_o == ST_INVERT));

endmodule

// File: rtl/sn_outmap.sv
module sn_outmap
    import sn_pkg::*;
(
    input  logic       vld_i,
    input  logic       din_i,
    input  neg_state_e mode_i,
    output logic       dout_o
);

    always_comb begin
        if (!vld_i) begin
            dout_o = 1'b0;
        end else if (mode_i == ST_INVERT) begin
            dout_o = ~din_i;
        end else begin
            dout_o = din_i;
        end
    end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
    import sn_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic vld_i,
    input  logic din_i,
    output logic dout_o
);

    neg_state_e mode;

    sn_state u_state (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .vld_i  (vld_i),
        .din_i  (din_i),
        .mode_o (mode)
    );

    sn_outmap u_outmap (
        .vld_i  (vld_i),
        .din_i  (din_i),
        .mode_i (mode),
        .dout_o (dout_o)
    );

    // R4: the result is 0 while idle
    a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |-> !dout_o);

    // R1: before any 1, data is copied through
    a_r1_copy: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && mode == ST_PASS) |-> (dout_o == din_i));

    // R7: after the first 1, the same cycle's bit is inverted
    a_r7_same_cycle_invert: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && mode == ST_INVERT) |-> (dout_o != din_i));

endmodule

// File: tb/serial_negator_bench.sv
module serial_negator_bench;

    localparam int HALF = 2;
    localparam int MAXW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic din = 1'b0;
    logic dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [MAXW-1:0] acc;
    logic [MAXW-1:0] got;
    int              nbits;

    always #HALF clk = ~clk;

    serial_negator u_serial_negator (
        .clk_i  (clk),
        .rst_i  (rst),
        .vld_i  (vld),
        .din_i  (din),
        .dout_o (dout)
    );

    function automatic logic neg_bit(logic [MAXW-1:0] a, int k);
        logic [MAXW-1:0] n;
        n = '0 - a;
        return n[k];
    endfunction

    task automatic check(string tag, logic g, logic e);
        n_cmp++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (bit %0d)", tag, g, e, nbits);
        end
    endtask

    // Drive on the falling edge, sample 1 ns later, before the rising edge.
    task automatic step(logic r, logic v, logic d);
        @(negedge clk);
        rst = r; vld = v; din = d;
        #1;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0);
        acc = '0; got = '0; nbits = 0;
    endtask

    // One valid bit, checked against the negation of the prefix (R1, R2, R3, R7).
    task automatic beat(logic d);
        step(1'b0, 1'b1, d);
        acc[nbits] = d;
        got[nbits] = dout;
        check("R3 prefix negation", dout, neg_bit(acc, nbits));
        nbits++;
    endtask

    // One idle cycle: the result must be 0 (R4).
    task automatic idle();
        step(1'b0, 1'b0, 1'($urandom_range(1)));
        check("R4 idle output zero", dout, 1'b0);
    endtask

    task automatic check_word(string tag);
        logic [MAXW-1:0] mask;
        logic [MAXW-1:0] expw;
        mask = (nbits >= MAXW) ? '1 : ((MAXW'(1) << nbits) - 1);
        expw = ('0 - acc) & mask;
        n_cmp++;
        if ((got & mask) !== expw) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got & mask, expw);
        end
    endtask

    task automatic random_word(int len, int idle_pct);
        do_reset();
        while (nbits < len) begin
            if ($urandom_range(99) < idle_pct) idle();
            else beat(1'($urandom_range(1)));
        end
        check_word("R3 whole word");
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // Reset state and R1: zeros pass, the first 1 passes.
        beat(1'b0);
        check("R1 zero copied", dout, 1'b0);
        beat(1'b0);
        beat(1'b1);
        check("R1 first one copied", dout, 1'b1);
        // R2: later bits inverted.
        beat(1'b1);
        check("R2 one inverted", dout, 1'b0);
        beat(1'b0);
        check("R2 zero inverted", dout, 1'b1);
        // R6: inversion survives idle cycles.
        idle(); idle(); idle();
        beat(1'b0);
        check("R6 sticky after idle", dout, 1'b1);
        check_word("R3 directed word");

        // R4: idle before the first 1 must not arm inversion.
        do_reset();
        step(1'b0, 1'b0, 1'b1);
        check("R4 idle with data one", dout, 1'b0);
        beat(1'b0);
        check("R4 state held across idle", dout, 1'b0);

        // R5: reset overrides valid with a data bit of 1.
        step(1'b1, 1'b1, 1'b1);
        acc = '0; got = '0; nbits = 0;
        beat(1'b0);
        check("R5 reset beats valid", dout, 1'b0);
        beat(1'b1);
        check("R5 first one after reset", dout, 1'b1);

        // All zeros: the negation is zero.
        do_reset();
        for (int i = 0; i < 20; i++) beat(1'b0);
        check_word("R1 all zeros");

        // Only the top bit set.
        do_reset();
        for (int i = 0; i < MAXW - 1; i++) beat(1'b0);
        beat(1'b1);
        check_word("R3 top bit only");

        // All ones: the result is 1 followed by zeros.
        do_reset();
        for (int i = 0; i < 32; i++) beat(1'b1);
        check_word("R2 all ones");

        // Random words with a mix of idle densities.
        for (int w = 0; w < 200; w++) begin
            random_word(1 + int'($urandom_range(MAXW - 1)), int'($urandom_range(60)));
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule